// File: doc/BRIEF.md
# Two-Wire Serial Program/Verify Command Engine

This block is the device-side receiver of a two-wire program/verify link. A host drives a serial clock and a data line. The block samples one bit on each falling clock edge and assembles a frame: a 4-bit command code first, then a 16-bit operand, both least significant bit first. The block decodes the code and hands a request to a table-access port or to the core's instruction port. Read-type commands turn the data line around after the eighth operand bit and return one byte on the same line. The data line is split into an input, an output and an output enable, and the pad ring joins them.

Operation is gated by a mode state. The block enters the mode only when the arm line rises while the serial clock and data are low and the program-enable input is high. It leaves the mode as soon as the arm line falls. While the mode is active, `mode_o` tells the pad ring to hold unused I/O at high impedance. The block keeps the table address pointer itself. A side load port presets the pointer, and each table command applies its own update rule to it.

Requests leave the block on a valid/ready interface. A request stays on the outputs, unchanged, until `req_ready` is seen high with `req_valid`. The host must not complete another request-issuing command while a request is still waiting. If it does, the block drops the new request and leaves the pointer as it was. All serial inputs pass through two-flop synchronizers, so the serial clock must be much slower than `clk`.

Top module: `sprog_engine`

## Requirements
- R1: After reset, `mode_o` goes high only when `arm_i` rises while `sclk_i` and `sdat_i` are low and `pgm_i` is high.
- R2: If any entry condition is missing when `arm_i` rises, the mode stays off. Frames shifted afterwards raise no request and never drive the data line.
- R3: A frame is 20 falling edges of `sclk_i`. The first 4 bits form the command code and the next 16 bits form the operand, each received least significant bit first.
- R4: Code 4'b0000 issues a core-instruction request (`req_kind` = 0) at the end of the frame, with `req_data` equal to the operand.
- R5: Codes 4'b1000, 4'b1001, 4'b1010 and 4'b1011 issue a table read (`req_kind` = 1) right after the code nibble. Their rules are:
  - 1000 uses the pointer and leaves it unchanged.
  - 1001 uses the pointer, then adds 1.
  - 1010 uses the pointer, then subtracts 1.
  - 1011 adds 1 first and uses the new value.
- R6: Codes 4'b1100, 4'b1101, 4'b1110 and 4'b1111 issue a table write (`req_kind` = 2) at frame end, with `req_data` equal to the operand. Their rules are:
  - 1100 leaves the pointer unchanged.
  - 1101 adds 2 after use.
  - 1110 sets `req_prog` and adds 2 after use.
  - 1111 sets `req_prog` and leaves the pointer unchanged.
  - `req_prog` is never set on any other request.
- R7: For code 4'b0010 and the four read codes, the block captures `tlat_i` at the 12th falling edge of the frame. It drives that byte on `sdat_o` least significant bit first, moving to the next bit at each later falling edge, with `sdat_oe` high. It releases the line at the 20th falling edge.
- R8: Codes 0001, 0011, 0100, 0101, 0110 and 0111 consume a full frame, raise no request and never drive the line. The next frame decodes normally.
- R9: When `arm_i` falls, `sdat_oe` drops in the same cycle, without waiting for a clock edge. The mode ends, and the next frame after re-entry starts again at bit 0.
- R10: While `req_valid` is high and `req_ready` is low, `req_valid` and every request field hold steady.
- R11: Reset clears the mode, the output enable and `req_valid`.
- R12: A pulse on `ptr_load_i` loads `ptr_val_i` into the pointer, and later table commands start from the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_i | input | 1 | Serial clock from the host |
| sdat_i | input | 1 | Serial data from the pad |
| sdat_o | output | 1 | Serial data returned to the pad |
| sdat_oe | output | 1 | Pad output enable for serial data |
| arm_i | input | 1 | Arm line; a qualified rise enters the mode, a fall leaves it |
| pgm_i | input | 1 | Program-enable level, checked when `arm_i` rises |
| mode_o | output | 1 | Mode active; the pad ring holds unused I/O at high impedance |
| tlat_i | input | 8 | Table latch byte returned by read-type commands |
| ptr_load_i | input | 1 | Load strobe for the table pointer |
| ptr_val_i | input | ADDR_W | Value loaded into the table pointer |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted by the downstream port |
| req_kind | output | 2 | 0 core instruction, 1 table read, 2 table write |
| req_addr | output | ADDR_W | Table address (zero for core requests) |
| req_data | output | 16 | Operand for core and write requests, zero for reads |
| req_prog | output | 1 | Start-programming flag on write requests |

## Verification
The assertions assume that a request-issuing command is never completed while an earlier request is still waiting. They also assume that `ptr_load_i` never pulses in the same cycle as a pointer update. Beyond that, they rely on the serial clock holding each level for several system clocks, so that the synchronizers see every edge. The stimulus bit-bangs the link with eight system clocks per serial half period and drives `ptr_load_i` only between frames. It holds `req_ready` low only around a single core-instruction frame.

// File: rtl/sprog_pkg.sv
package sprog_pkg;

  localparam int CMD_W  = 4;
  localparam int OPR_W  = 16;
  localparam int BYTE_W = 8;
  localparam int FRAME_LEN = CMD_W + OPR_W;
  localparam int DRIVE_FROM = FRAME_LEN - BYTE_W;

  // Command codes: fixed by the host protocol.
  localparam logic [3:0] C_CORE        = 4'b0000;
  localparam logic [3:0] C_LATCH       = 4'b0010;
  localparam logic [3:0] C_RD          = 4'b1000;
  localparam logic [3:0] C_RD_POSTINC  = 4'b1001;
  localparam logic [3:0] C_RD_POSTDEC  = 4'b1010;
  localparam logic [3:0] C_RD_PREINC   = 4'b1011;
  localparam logic [3:0] C_WR          = 4'b1100;
  localparam logic [3:0] C_WR_INC2     = 4'b1101;
  localparam logic [3:0] C_WR_PGM_INC2 = 4'b1110;
  localparam logic [3:0] C_WR_PGM      = 4'b1111;

  typedef enum logic [1:0] {
    RQ_CORE = 2'd0,
    RQ_TRD  = 2'd1,
    RQ_TWR  = 2'd2
  } rq_kind_e;

endpackage

// File: rtl/sprog_sync.sv
module sprog_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sprog_shifter.sv
module sprog_shifter #(
  parameter int CMD_W = 4,
  parameter int OPR_W = 16,
  parameter int OUT_W = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                active,
  input  logic                                fall,
  input  logic                                din,
  output logic [CMD_W-1:0]                    cmd_o,
  output logic [OPR_W-1:0]                    opr_o,
  output logic [$clog2(CMD_W+OPR_W+1)-1:0]    idx_o,
  output logic                                cmd_done_o,
  output logic                                frame_done_o,
  output logic                                half_edge_o,
  output logic                                last_edge_o
);

  localparam int FRAME = CMD_W + OPR_W;
  localparam int IW    = $clog2(FRAME + 1);
  localparam logic [IW-1:0] K_CMD_LAST = IW'(CMD_W - 1);
  localparam logic [IW-1:0] K_HALF     = IW'(FRAME - OUT_W - 1);
  localparam logic [IW-1:0] K_LAST     = IW'(FRAME - 1);

  logic [IW-1:0]    idx_q;
  logic [CMD_W-1:0] cmd_sr;
  logic [OPR_W-1:0] opr_sr;
  logic             at_fall;

  assign at_fall     = active & fall;
  assign half_edge_o = at_fall & (idx_q == K_HALF);
  assign last_edge_o = at_fall & (idx_q == K_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q        <= '0;
      cmd_sr       <= '0;
      opr_sr       <= '0;
      cmd_done_o   <= 1'b0;
      frame_done_o <= 1'b0;
    end else begin
      cmd_done_o   <= at_fall & (idx_q == K_CMD_LAST);
      frame_done_o <= last_edge_o;
      if (!active) begin
        idx_q <= '0;
      end else if (fall) begin
        // LSB arrives first: shift in from the top.
        if (idx_q <= K_CMD_LAST) cmd_sr <= {din, cmd_sr[CMD_W-1:1]};
        else                     opr_sr <= {din, opr_sr[OPR_W-1:1]};
        idx_q <= (idx_q == K_LAST) ? '0 : idx_q + IW'(1);
      end
    end
  end

  assign cmd_o = cmd_sr;
  assign opr_o = opr_sr;
  assign idx_o = idx_q;

endmodule

// File: rtl/sprog_exec.sv
module sprog_exec
  import sprog_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int OPR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_done,
  input  logic              frame_done,
  input  logic [3:0]        cmd,
  input  logic [OPR_W-1:0]  opr,
  input  logic              ptr_load,
  input  logic [ADDR_W-1:0] ptr_val,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [1:0]        req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [OPR_W-1:0]  req_data,
  output logic              req_prog,
  output logic              rd_cmd
);

  logic [ADDR_W-1:0] ptr_q, use_addr, ptr_nxt;
  logic              fire, use_prog, slot_free;
  rq_kind_e          use_kind;
  logic [OPR_W-1:0]  use_data;

  assign rd_cmd    = (cmd == C_LATCH) || (cmd[3:2] == 2'b10);
  assign slot_free = !req_valid || req_ready;

  always_comb begin
    fire     = 1'b0;
    use_kind = RQ_CORE;
    use_addr = ptr_q;
    ptr_nxt  = ptr_q;
    use_prog = 1'b0;
    use_data = '0;
    if (cmd_done) begin
      case (cmd)
        C_RD:         begin fire = 1'b1; use_kind = RQ_TRD; end
        C_RD_POSTINC: begin fire = 1'b1; use_kind = RQ_TRD; ptr_nxt = ptr_q + ADDR_W'(1); end
        C_RD_POSTDEC: begin fire = 1'b1; use_kind = RQ_TRD; ptr_nxt = ptr_q - ADDR_W'(1); end
        C_RD_PREINC: begin
          fire     = 1'b1;
          use_kind = RQ_TRD;
          use_addr = ptr_q + ADDR_W'(1);
          ptr_nxt  = ptr_q + ADDR_W'(1);
        end
        default: ;
      endcase
    end else if (frame_done) begin
      use_data = opr;
      case (cmd)
        C_CORE:        begin fire = 1'b1; use_kind = RQ_CORE; use_addr = '0; end
        C_WR:          begin fire = 1'b1; use_kind = RQ_TWR; end
        C_WR_INC2:     begin fire = 1'b1; use_kind = RQ_TWR; ptr_nxt = ptr_q + ADDR_W'(2); end
        C_WR_PGM_INC2: begin
          fire     = 1'b1;
          use_kind = RQ_TWR;
          use_prog = 1'b1;
          ptr_nxt  = ptr_q + ADDR_W'(2);
        end
        C_WR_PGM:      begin fire = 1'b1; use_kind = RQ_TWR; use_prog = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      req_valid <= 1'b0;
      req_kind  <= RQ_CORE;
      req_addr  <= '0;
      req_data  <= '0;
      req_prog  <= 1'b0;
    end else begin
      if (ptr_load)               ptr_q <= ptr_val;
      else if (fire && slot_free) ptr_q <= ptr_nxt;

      if (req_valid && req_ready) req_valid <= 1'b0;
      if (fire && slot_free) begin
        req_valid <= 1'b1;
        req_kind  <= use_kind;
        req_addr  <= use_addr;
        req_data  <= use_data;
        req_prog  <= use_prog;
      end
    end
  end

endmodule

// File: rtl/sprog_tx.sv
module sprog_tx #(
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             fall,
  input  logic             half_edge,
  input  logic             last_edge,
  input  logic             rd_cmd,
  input  logic [OUT_W-1:0] tlat,
  output logic             drv_o,
  output logic             bit_o
);

  logic [OUT_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv_o <= 1'b0;
      sr_q  <= '0;
    end else if (!active) begin
      drv_o <= 1'b0;
    end else if (half_edge && rd_cmd) begin
      drv_o <= 1'b1;
      sr_q  <= tlat;
    end else if (last_edge) begin
      drv_o <= 1'b0;
    end else if (drv_o && fall) begin
      sr_q <= sr_q >> 1;
    end
  end

  assign bit_o = sr_q[0];

endmodule

// File: rtl/sprog_engine.sv
module sprog_engine
  import sprog_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdat_i,
  output logic              sdat_o,
  output logic              sdat_oe,
  input  logic              arm_i,
  input  logic              pgm_i,
  output logic              mode_o,
  input  logic [BYTE_W-1:0] tlat_i,
  input  logic              ptr_load_i,
  input  logic [ADDR_W-1:0] ptr_val_i,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [1:0]        req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [OPR_W-1:0]  req_data,
  output logic              req_prog
);

  localparam int IDX_W = $clog2(FRAME_LEN + 1);

  logic [3:0]       pins_s;
  logic             sclk_s, sdat_s, arm_s, pgm_s;
  logic             sclk_q, arm_q, mode_q, active, fall, arm_rise;
  logic [CMD_W-1:0] cmd;
  logic [OPR_W-1:0] opr;
  logic [IDX_W-1:0] frame_idx;
  logic             cmd_done, frame_done, half_edge, last_edge, rd_cmd, drv;

  sprog_sync #(.W(4), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({pgm_i, arm_i, sdat_i, sclk_i}),
    .q(pins_s)
  );
  assign {pgm_s, arm_s, sdat_s, sclk_s} = pins_s;

  assign fall     = sclk_q & ~sclk_s;
  assign arm_rise = arm_s & ~arm_q;
  assign active   = mode_q & arm_s;

  // Mode entry is qualified only at the arm edge; any arm low exits.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      arm_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      arm_q  <= arm_s;
      if (!arm_s)                                  mode_q <= 1'b0;
      else if (arm_rise && !sclk_s && !sdat_s && pgm_s) mode_q <= 1'b1;
    end
  end

  sprog_shifter #(.CMD_W(CMD_W), .OPR_W(OPR_W), .OUT_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .active(active), .fall(fall), .din(sdat_s),
    .cmd_o(cmd), .opr_o(opr), .idx_o(frame_idx),
    .cmd_done_o(cmd_done), .frame_done_o(frame_done),
    .half_edge_o(half_edge), .last_edge_o(last_edge)
  );

  sprog_exec #(.ADDR_W(ADDR_W), .OPR_W(OPR_W)) u_exec (
    .clk(clk), .rst_n(rst_n),
    .cmd_done(cmd_done & active), .frame_done(frame_done & active),
    .cmd(cmd), .opr(opr),
    .ptr_load(ptr_load_i), .ptr_val(ptr_val_i), .req_ready(req_ready),
    .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
    .req_data(req_data), .req_prog(req_prog), .rd_cmd(rd_cmd)
  );

  sprog_tx #(.OUT_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .active(active), .fall(fall),
    .half_edge(half_edge), .last_edge(last_edge), .rd_cmd(rd_cmd),
    .tlat(tlat_i), .drv_o(drv), .bit_o(sdat_o)
  );

  // Raw arm gates the pad so an exit releases the line at once.
  assign sdat_oe = drv & arm_i;
  assign mode_o  = mode_q;

endmodule

// File: rtl/sprog_engine_chk.sv
module sprog_engine_chk
  import sprog_pkg::*;
#(
  parameter int AW = 22,
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_o,
  input logic          sdat_oe,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_kind,
  input logic [AW-1:0] req_addr,
  input logic [15:0]   req_data,
  input logic          req_prog,
  input logic [IW-1:0] frame_idx
);

  a_r10_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid);

  a_r10_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> $stable(req_addr) && $stable(req_data)
                                && $stable(req_kind) && $stable(req_prog));

  a_r2_issue_in_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> mode_o);

  a_r9_idle_out_of_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_o |-> !sdat_oe && (frame_idx == '0));

  a_r7_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
    sdat_oe |-> frame_idx >= IW'(DRIVE_FROM));

  a_r3_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    frame_idx < IW'(FRAME_LEN));

  a_r6_prog_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_prog |-> req_kind == 2'(RQ_TWR));

endmodule

bind sprog_engine sprog_engine_chk #(.AW(ADDR_W), .IW(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .sdat_oe(sdat_oe),
  .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
  .req_addr(req_addr), .req_data(req_data), .req_prog(req_prog),
  .frame_idx(frame_idx)
);

// File: tb/sprog_engine_tb_top.sv
module sprog_engine_tb_top;

  localparam int AW = 22;
  localparam int H  = 8;   // system clocks per serial half period
  localparam int NV = 14;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic          rst_n = 1'b0;
  logic          sclk_i = 1'b0, sdat_i = 1'b0, arm_i = 1'b0, pgm_i = 1'b0;
  logic          sdat_o, sdat_oe, mode_o;
  logic [7:0]    tlat_i = 8'h00;
  logic          ptr_load_i = 1'b0;
  logic [AW-1:0] ptr_val_i = '0;
  logic          req_valid, req_ready = 1'b1, req_prog;
  logic [1:0]    req_kind;
  logic [AW-1:0] req_addr;
  logic [15:0]   req_data;

  sprog_engine #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdat_i(sdat_i),
    .sdat_o(sdat_o), .sdat_oe(sdat_oe), .arm_i(arm_i), .pgm_i(pgm_i),
    .mode_o(mode_o), .tlat_i(tlat_i), .ptr_load_i(ptr_load_i),
    .ptr_val_i(ptr_val_i), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data),
    .req_prog(req_prog)
  );

  int n_chk = 0, n_bad = 0;
  int n_req = 0;
  logic [1:0]  last_kind;
  logic [15:0] last_addr, last_data;
  logic        last_prog;

  // Accepted-request monitor, sampled mid-cycle.
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      n_req     <= n_req + 1;
      last_kind <= req_kind;
      last_addr <= req_addr[15:0];
      last_data <= req_data;
      last_prog <= req_prog;
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // Vector: cmd, operand, expect-request, kind, addr, prog, expect-drive, tlat byte.
  localparam logic [48:0] VEC [NV] = '{
    {4'b0000, 16'h1234, 1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 8'h00},  // R4 core
    {4'b1000, 16'h0000, 1'b1, 2'd1, 16'h0100, 1'b0, 1'b1, 8'hA5},  // R5 plain read
    {4'b1001, 16'h0000, 1'b1, 2'd1, 16'h0100, 1'b0, 1'b1, 8'h3C},  // R5 post-inc
    {4'b1011, 16'h0000, 1'b1, 2'd1, 16'h0102, 1'b0, 1'b1, 8'h81},  // R5 pre-inc
    {4'b1010, 16'h0000, 1'b1, 2'd1, 16'h0102, 1'b0, 1'b1, 8'h00},  // R5 post-dec
    {4'b0010, 16'hFFFF, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 8'hFF},  // R7 latch only
    {4'b1100, 16'hBEEF, 1'b1, 2'd2, 16'h0101, 1'b0, 1'b0, 8'h00},  // R6 write
    {4'b1101, 16'h0F0F, 1'b1, 2'd2, 16'h0101, 1'b0, 1'b0, 8'h00},  // R6 +2
    {4'b1110, 16'h5555, 1'b1, 2'd2, 16'h0103, 1'b1, 1'b0, 8'h00},  // R6 prog +2
    {4'b1111, 16'hAAAA, 1'b1, 2'd2, 16'h0105, 1'b1, 1'b0, 8'h00},  // R6 prog
    {4'b0101, 16'h1357, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 8'h00},  // R8
    {4'b1000, 16'h0000, 1'b1, 2'd1, 16'h0105, 1'b0, 1'b1, 8'h6E},  // R8 follow-up
    {4'b0111, 16'h2468, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 8'h00},  // R8
    {4'b0001, 16'hFACE, 1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 8'h00}   // R8
  };

  // Bit-bangs nbits of a frame; checks the returned byte (or no drive) in bits 12..19.
  task automatic shift_bits(input logic [3:0] c, input logic [15:0] op, input int nbits,
                            input bit exp_out, input logic [7:0] eb, output bit ok);
    ok = 1'b1;
    for (int b = 0; b < nbits; b++) begin
      sclk_i = 1'b1;
      sdat_i = (b < 4) ? c[b] : op[b-4];
      repeat (H) @(negedge clk);
      if (b >= 12) begin
        if (exp_out) begin
          if (!(sdat_oe && sdat_o == eb[b-12])) ok = 1'b0;
        end else if (sdat_oe) ok = 1'b0;
      end
      sclk_i = 1'b0;
      repeat (H) @(negedge clk);
    end
    sdat_i = 1'b0;
  endtask

  task automatic load_ptr(input logic [AW-1:0] v);
    @(negedge clk);
    ptr_val_i  = v;
    ptr_load_i = 1'b1;
    @(negedge clk);
    ptr_load_i = 1'b0;
  endtask

  task automatic arm_cycle(input bit dat, input bit pgm);
    arm_i = 1'b0;
    repeat (6) @(negedge clk);
    sclk_i = 1'b0;
    sdat_i = dat;
    pgm_i  = pgm;
    repeat (6) @(negedge clk);
    arm_i = 1'b1;
    repeat (8) @(negedge clk);
    sdat_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    bit ok;
    int n0;
    repeat (5) @(negedge clk);
    // R11: reset state
    check(!mode_o && !sdat_oe && !req_valid, "R11", "idle after reset",
          {mode_o, sdat_oe, req_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!mode_o && !req_valid, "R11", "idle after release", {mode_o, req_valid}, 0);

    load_ptr(AW'(16'h0100));

    // R2: data high at arm rise
    arm_cycle(1'b1, 1'b1);
    check(!mode_o, "R2", "entry with data high", mode_o, 0);
    // R2: program enable low at arm rise
    arm_cycle(1'b0, 1'b0);
    check(!mode_o, "R2", "entry with pgm low", mode_o, 0);
    n0 = n_req;
    tlat_i = 8'h77;
    shift_bits(4'b1000, 16'h0000, 20, 1'b0, 8'h00, ok);
    repeat (4) @(negedge clk);
    check(ok && n_req == n0, "R2", "frame outside mode", n_req, n0);

    // R1: qualified entry
    arm_cycle(1'b0, 1'b1);
    check(mode_o, "R1", "qualified entry", mode_o, 1);

    // R3..R8: vector walk
    for (int i = 0; i < NV; i++) begin
      logic [48:0] v;
      v = VEC[i];
      tlat_i = v[7:0];
      n0 = n_req;
      shift_bits(v[48:45], v[44:29], 20, v[8], v[7:0], ok);
      repeat (H) @(negedge clk);
      if (sdat_oe) ok = 1'b0;
      check(ok, "R7", $sformatf("vec %0d line drive", i), {31'd0, ok}, 1);
      check(n_req == n0 + int'(v[28]), "R3", $sformatf("vec %0d request count", i),
            n_req - n0, v[28]);
      if (v[28]) begin
        check(last_kind == v[27:26], "R5", $sformatf("vec %0d kind", i), last_kind, v[27:26]);
        if (v[27:26] != 2'd0)
          check(last_addr == v[25:10], "R6", $sformatf("vec %0d addr", i), last_addr, v[25:10]);
        check(last_prog == v[9], "R6", $sformatf("vec %0d prog", i), last_prog, v[9]);
        if (v[27:26] != 2'd1)
          check(last_data == v[44:29], "R4", $sformatf("vec %0d data", i), last_data, v[44:29]);
      end
    end

    // R10: back-pressure holds the request
    @(posedge clk);
    #1 req_ready = 1'b0;
    n0 = n_req;
    shift_bits(4'b0000, 16'hC0DE, 20, 1'b0, 8'h00, ok);
    repeat (4) @(negedge clk);
    check(req_valid && req_data == 16'hC0DE, "R10", "pending request", req_data, 16'hC0DE);
    repeat (20) @(negedge clk);
    check(req_valid && req_data == 16'hC0DE && req_kind == 2'd0, "R10", "still pending",
          req_data, 16'hC0DE);
    @(posedge clk);
    #1 req_ready = 1'b1;
    repeat (4) @(negedge clk);
    check(n_req == n0 + 1 && last_data == 16'hC0DE && !req_valid, "R10", "accepted once",
          n_req - n0, 1);

    // R9: drop arm in the middle of an output phase
    tlat_i = 8'hFF;
    shift_bits(4'b1000, 16'h0000, 14, 1'b1, 8'hFF, ok);
    sclk_i = 1'b1;
    repeat (H) @(negedge clk);
    check(sdat_oe, "R9", "driving before exit", sdat_oe, 1);
    arm_i = 1'b0;
    #1;
    check(!sdat_oe, "R9", "immediate release", sdat_oe, 0);
    sclk_i = 1'b0;
    repeat (8) @(negedge clk);
    check(!mode_o, "R9", "mode left", mode_o, 0);
    arm_cycle(1'b0, 1'b1);
    n0 = n_req;
    shift_bits(4'b0000, 16'h7E81, 20, 1'b0, 8'h00, ok);
    repeat (4) @(negedge clk);
    check(n_req == n0 + 1 && last_data == 16'h7E81 && last_kind == 2'd0, "R9",
          "fresh frame after re-entry", last_data, 16'h7E81);

    // R12: pointer load then post-increment read chain
    load_ptr(AW'(16'h0200));
    tlat_i = 8'h12;
    shift_bits(4'b1001, 16'h0000, 20, 1'b1, 8'h12, ok);
    repeat (4) @(negedge clk);
    check(ok && last_addr == 16'h0200, "R12", "loaded pointer used", last_addr, 16'h0200);
    shift_bits(4'b1000, 16'h0000, 20, 1'b1, 8'h12, ok);
    repeat (4) @(negedge clk);
    check(ok && last_addr == 16'h0201, "R12", "pointer advanced", last_addr, 16'h0201);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule